// File: doc/BRIEF.md
# Dual Masked Alarm with Shared Interrupt / Clock Output

This block watches a running calendar clock and reports when it reaches either of two programmed alarm settings. Each alarm has six comparison bytes (seconds, minutes, hours, date, month, weekday). The top bit of each byte decides whether that field takes part in the comparison, so one alarm can fire once a minute, on a given weekday, or at one exact instant. There is no year field. A match is sampled on the one-second tick. It raises a sticky status flag for that alarm. A status read clears the flags, but only those that were already set when the read began.

One output drives an active-low open-drain pin that has two uses. With the frequency code at zero, the pin is an interrupt. In level mode it is held low while an enabled alarm's flag is set. In pulse mode it goes low for half a second on every match. With any other code the interrupt is off, and the pin carries one of three clocks derived from the 32.768 kHz enable.

The register storage and the serial bus sit outside this block. They feed the alarm bytes, the control bits and the two read strobes.

Top module: `alarm_irq_unit`

## Requirements
- R1: Byte k of a 48-bit bus carries one field: k=0 seconds, k=1 minutes, k=2 hours, k=3 date, k=4 month, k=5 weekday. An alarm matches when, for every alarm byte whose bit 7 is 1, bits 6:0 equal bits 6:0 of the same clock byte. Bytes with bit 7 at 0 are ignored.
- R2: An alarm with no bit 7 set in any of its bytes never matches.
- R3: A match is only sampled in a cycle where tick_1s is 1. The flag goes to 1 on that clock edge, so it is visible in the next cycle. Without a tick, a matching time sets nothing.
- R4: sr_rd_start records which flags are set. sr_rd_end clears exactly those recorded flags. A flag set after the start survives the end. A match at the same edge as sr_rd_end leaves its flag set.
- R5: Level mode applies with fsel=00 and pulse_mode=0. In that mode pin_pull is 1 one cycle after the flag of an alarm whose interrupt enable is 1 is set, and it stays 1 until that flag is cleared.
- R6: Pulse mode applies with fsel=00 and pulse_mode=1. A sampled match of an enabled alarm makes pin_pull 1 from the next cycle on. It stays 1 for 2^(DIV_W-1) tick_32k pulses. A further match restarts the count.
- R7: The frequency codes select the pin source as follows, and no alarm interrupt reaches the pin for any nonzero code:
  - fsel=01: pin_pull is tick_32k delayed by one cycle.
  - fsel=10: pin_pull is the inverse of bit MID_BIT of a free-running count of tick_32k pulses.
  - fsel=11: pin_pull is the inverse of bit DIV_W-1 of the same count.
- R8: With both interrupt enables 0 and fsel=00, pin_pull stays 0, while the flags still follow matches.
- R9: After reset the flags, pin_pull, the divider and the pulse timer are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1s | input | 1 | One-cycle pulse per second; alarm sample strobe |
| tick_32k | input | 1 | 32.768 kHz clock enable |
| clk_time | input | 48 | Live BCD clock fields, byte k as in R1 |
| alm0_cfg | input | 48 | Alarm 0 bytes, bit 7 of each byte is its field enable |
| alm1_cfg | input | 48 | Alarm 1 bytes, same layout |
| pulse_mode | input | 1 | 1 = pulsed interrupt, 0 = level interrupt |
| irq_en0 | input | 1 | Alarm 0 interrupt enable |
| irq_en1 | input | 1 | Alarm 1 interrupt enable |
| fsel | input | 2 | Pin source: 00 interrupt, 01/10/11 clocks |
| sr_rd_start | input | 1 | Status read begins (one-cycle strobe) |
| sr_rd_end | input | 1 | Status read ends (one-cycle strobe) |
| flag0 | output | 1 | Alarm 0 status flag |
| flag1 | output | 1 | Alarm 1 status flag |
| pin_pull | output | 1 | 1 = pull the open-drain pin low |

## Verification
The alarms are tried against times that match only on their enabled fields, that differ only in a masked-out field, and that differ in one enabled field. A mismatch on a masked field must still fire and a mismatch on an enabled field must not, which separates correct masking from plain equality. Alarms with no enabled fields, and matching times with no tick, show whether the empty mask and the sample strobe are honoured. Status reads with a match arriving mid-read, and matches arriving on the ending strobe, separate the recorded clear from a blanket clear. The pin is then swept through level, pulse with retrigger, all three frequency codes and both enables off, against a per-cycle reference model.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int FIELDS = 6;
  localparam int BUS_W  = 8 * FIELDS;

  typedef enum logic [1:0] {
    PIN_IRQ  = 2'b00,
    PIN_FAST = 2'b01,
    PIN_MID  = 2'b10,
    PIN_SLOW = 2'b11
  } pin_src_e;
endpackage

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_pkg::*;
(
  input  logic [BUS_W-1:0] clk_time,
  input  logic [BUS_W-1:0] cfg,
  output logic             hit
);
  logic [FIELDS-1:0] use_f;
  logic [FIELDS-1:0] ok_f;

  for (genvar k = 0; k < FIELDS; k++) begin : g_field
    assign use_f[k] = cfg[8*k+7];
    assign ok_f[k]  = !use_f[k] || (cfg[8*k +: 7] == clk_time[8*k +: 7]);
  end

  assign hit = (|use_f) && (&ok_f);
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk,
  input  logic rst,
  input  logic event_in,
  input  logic rd_start,
  input  logic rd_end,
  output logic flag
);
  logic snap;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      snap <= 1'b0;
    end else begin
      if (rd_end) begin
        flag <= (flag & ~snap) | event_in;
        snap <= 1'b0;
      end else begin
        flag <= flag | event_in;
        if (rd_start) snap <= flag;
      end
    end
  end
endmodule

// File: rtl/freq_div.sv
module freq_div #(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_32k,
  output logic [DIV_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)           count <= '0;
    else if (tick_32k) count <= count + 1'b1;
  end
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int DIV_W = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic tick_32k,
  output logic active
);
  localparam logic [DIV_W-1:0] HALF = DIV_W'(1) << (DIV_W - 1);

  logic [DIV_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                             remain <= '0;
    else if (load)                       remain <= HALF;
    else if (tick_32k && remain != '0)   remain <= remain - 1'b1;
  end

  assign active = (remain != '0);
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import alarm_pkg::*;
#(
  parameter int DIV_W   = 15,
  parameter int MID_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1s,
  input  logic              tick_32k,
  input  logic [47:0]       clk_time,
  input  logic [47:0]       alm0_cfg,
  input  logic [47:0]       alm1_cfg,
  input  logic              pulse_mode,
  input  logic              irq_en0,
  input  logic              irq_en1,
  input  logic [1:0]        fsel,
  input  logic              sr_rd_start,
  input  logic              sr_rd_end,
  output logic              flag0,
  output logic              flag1,
  output logic              pin_pull
);
  localparam int NUM_ALM = 2;

  logic [BUS_W-1:0]   cfg_arr [NUM_ALM];
  logic [NUM_ALM-1:0] hit;
  logic [NUM_ALM-1:0] evt;
  logic [NUM_ALM-1:0] flags;
  logic [NUM_ALM-1:0] irq_en;
  logic [DIV_W-1:0]   div_cnt;
  logic               pulse_on;
  logic               pin_next;
  pin_src_e           src;

  assign cfg_arr[0] = alm0_cfg;
  assign cfg_arr[1] = alm1_cfg;
  assign irq_en     = {irq_en1, irq_en0};
  assign src        = pin_src_e'(fsel);

  for (genvar a = 0; a < NUM_ALM; a++) begin : g_alarm
    alarm_match u_match (
      .clk_time (clk_time),
      .cfg      (cfg_arr[a]),
      .hit      (hit[a])
    );
    assign evt[a] = tick_1s & hit[a];
    alarm_flag u_flag (
      .clk      (clk),
      .rst      (rst),
      .event_in (evt[a]),
      .rd_start (sr_rd_start),
      .rd_end   (sr_rd_end),
      .flag     (flags[a])
    );
  end

  freq_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .tick_32k (tick_32k),
    .count    (div_cnt)
  );

  pulse_timer #(.DIV_W(DIV_W)) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .load     (|(evt & irq_en)),
    .tick_32k (tick_32k),
    .active   (pulse_on)
  );

  always_comb begin
    unique case (src)
      PIN_IRQ:  pin_next = (|irq_en) &&
                           (pulse_mode ? pulse_on : |(flags & irq_en));
      PIN_FAST: pin_next = tick_32k;
      PIN_MID:  pin_next = ~div_cnt[MID_BIT];
      PIN_SLOW: pin_next = ~div_cnt[DIV_W-1];
      default:  pin_next = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pin_pull <= 1'b0;
    else     pin_pull <= pin_next;
  end

  assign flag0 = flags[0];
  assign flag1 = flags[1];
endmodule

// File: rtl/alarm_irq_checks.sv
module alarm_irq_checks (
  input logic        clk,
  input logic        rst,
  input logic        tick_1s,
  input logic        tick_32k,
  input logic [47:0] alm0_cfg,
  input logic        pulse_mode,
  input logic        irq_en0,
  input logic        irq_en1,
  input logic [1:0]  fsel,
  input logic        sr_rd_end,
  input logic        flag0,
  input logic        flag1,
  input logic        pin_pull
);
  logic alm0_empty;
  assign alm0_empty = !(alm0_cfg[7] | alm0_cfg[15] | alm0_cfg[23] |
                        alm0_cfg[31] | alm0_cfg[39] | alm0_cfg[47]);

  assert_rise_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(flag0) || $rose(flag1)) |-> $past(tick_1s));

  assert_fall_on_read_end_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(flag0) || $fell(flag1)) |-> $past(sr_rd_end));

  assert_empty_mask_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_1s && alm0_empty && !flag0) |=> !flag0);

  assert_level_pin_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(fsel) == 2'b00 && !$past(pulse_mode) &&
     $past(irq_en0) && $past(flag0)) |-> pin_pull);

  assert_fast_clock_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(fsel) == 2'b01) |-> (pin_pull == $past(tick_32k)));

  assert_no_irq_when_off_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(fsel) == 2'b00 && !$past(irq_en0) && !$past(irq_en1))
    |-> !pin_pull);
endmodule

bind alarm_irq_unit alarm_irq_checks u_checks (
  .clk        (clk),
  .rst        (rst),
  .tick_1s    (tick_1s),
  .tick_32k   (tick_32k),
  .alm0_cfg   (alm0_cfg),
  .pulse_mode (pulse_mode),
  .irq_en0    (irq_en0),
  .irq_en1    (irq_en1),
  .fsel       (fsel),
  .sr_rd_end  (sr_rd_end),
  .flag0      (flag0),
  .flag1      (flag1),
  .pin_pull   (pin_pull)
);

// File: tb/test_alarm_irq_unit.sv
`timescale 1ns/1ps
module test_alarm_irq_unit;
  localparam int DIV_W   = 6;
  localparam int MID_BIT = 2;
  localparam int HALF    = 1 << (DIV_W - 1);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1s = 1'b0;
  logic        tick_32k = 1'b0;
  logic [47:0] clk_time = '0;
  logic [47:0] alm0_cfg = '0;
  logic [47:0] alm1_cfg = '0;
  logic        pulse_mode = 1'b0;
  logic        irq_en0 = 1'b0;
  logic        irq_en1 = 1'b0;
  logic [1:0]  fsel = 2'b00;
  logic        sr_rd_start = 1'b0;
  logic        sr_rd_end = 1'b0;
  logic        flag0, flag1, pin_pull;

  int    total = 0;
  int    bad = 0;
  string cur_req = "R9";
  int    t32_period = 0;
  int    t32_phase = 0;
  bit    done = 0;

  // reference model state
  int m_flag[2], m_snap[2], m_div, m_cnt, m_pin;

  always #4 clk = ~clk;

  alarm_irq_unit #(.DIV_W(DIV_W), .MID_BIT(MID_BIT)) i_alarm_irq_unit (
    .clk(clk), .rst(rst), .tick_1s(tick_1s), .tick_32k(tick_32k),
    .clk_time(clk_time), .alm0_cfg(alm0_cfg), .alm1_cfg(alm1_cfg),
    .pulse_mode(pulse_mode), .irq_en0(irq_en0), .irq_en1(irq_en1),
    .fsel(fsel), .sr_rd_start(sr_rd_start), .sr_rd_end(sr_rd_end),
    .flag0(flag0), .flag1(flag1), .pin_pull(pin_pull)
  );

  function automatic int model_match(logic [47:0] cfg, logic [47:0] tm);
    int any = 0;
    int ok = 1;
    for (int k = 0; k < 6; k++) begin
      if (cfg[8*k+7]) begin
        any = 1;
        if (cfg[8*k +: 7] != tm[8*k +: 7]) ok = 0;
      end
    end
    return any & ok;
  endfunction

  function automatic logic [47:0] pack_t(int sc, int mn, int hr, int dt, int mo, int wd);
    return {wd[7:0], mo[7:0], dt[7:0], hr[7:0], mn[7:0], sc[7:0]};
  endfunction

  always @(posedge clk) begin
    int ev[2];
    int en[2];
    int pn;
    if (rst) begin
      m_flag = '{0, 0}; m_snap = '{0, 0};
      m_div = 0; m_cnt = 0; m_pin = 0;
    end else begin
      en[0] = irq_en0; en[1] = irq_en1;
      ev[0] = tick_1s && model_match(alm0_cfg, clk_time);
      ev[1] = tick_1s && model_match(alm1_cfg, clk_time);
      case (fsel)
        2'b00: pn = (en[0] || en[1]) &&
                    (pulse_mode ? (m_cnt != 0)
                                : ((en[0] && m_flag[0]) || (en[1] && m_flag[1])));
        2'b01: pn = tick_32k;
        2'b10: pn = ((m_div >> MID_BIT) & 1) == 0;
        default: pn = ((m_div >> (DIV_W - 1)) & 1) == 0;
      endcase
      for (int a = 0; a < 2; a++) begin
        if (sr_rd_end) begin
          m_flag[a] = (m_flag[a] && !m_snap[a]) || ev[a];
          m_snap[a] = 0;
        end else begin
          if (sr_rd_start) m_snap[a] = m_flag[a];
          m_flag[a] = m_flag[a] || ev[a];
        end
      end
      if ((ev[0] && en[0]) || (ev[1] && en[1])) m_cnt = HALF;
      else if (tick_32k && m_cnt > 0) m_cnt = m_cnt - 1;
      if (tick_32k) m_div = (m_div + 1) % (1 << DIV_W);
      m_pin = pn;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(cur_req, flag0, m_flag[0], "flag0");
      check(cur_req, flag1, m_flag[1], "flag1");
      check(cur_req, pin_pull, m_pin, "pin_pull");
    end
  end

  // 32 kHz enable generator
  initial begin
    forever begin
      @(negedge clk); #1;
      if (t32_period == 0) tick_32k = 1'b0;
      else begin
        tick_32k = (t32_phase == 0);
        t32_phase = (t32_phase + 1) % t32_period;
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic sec_tick();
    @(negedge clk); #1 tick_1s = 1'b1;
    @(negedge clk); #1 tick_1s = 1'b0;
  endtask

  task automatic rd_pulse(bit s, bit e);
    @(negedge clk); #1 sr_rd_start = s; sr_rd_end = e;
    @(negedge clk); #1 sr_rd_start = 1'b0; sr_rd_end = 1'b0;
  endtask

  // watchdog
  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check("R9", flag0, 0, "flag0 after reset");
    check("R9", flag1, 0, "flag1 after reset");
    check("R9", pin_pull, 0, "pin after reset");

    // R1: masked comparison. alm0 uses seconds+minutes, alm1 uses hour (mismatch)
    cur_req = "R1";
    alm0_cfg = pack_t(8'hB0, 8'h95, 8'h09, 8'h03, 8'h04, 8'h02);
    alm1_cfg = pack_t(8'h30, 8'h15, 8'h88, 8'h00, 8'h00, 8'h00);
    clk_time = pack_t(8'h30, 8'h15, 8'h07, 8'h21, 8'h03, 8'h05);
    sec_tick();
    @(negedge clk);
    check("R1", flag0, 1, "masked-out fields differ, enabled match");
    check("R1", flag1, 0, "enabled hour differs");

    // R4: clear only recorded flags; alm1 hit during the read survives
    cur_req = "R4";
    alm1_cfg = pack_t(8'h00, 8'h00, 8'h87, 8'h00, 8'h00, 8'h00);
    rd_pulse(1, 0);
    sec_tick();
    rd_pulse(0, 1);
    @(negedge clk);
    check("R4", flag0, 0, "recorded flag cleared");
    check("R4", flag1, 1, "flag set during read kept");
    // match arriving on the end strobe
    rd_pulse(1, 0);
    @(negedge clk); #1 tick_1s = 1'b1; sr_rd_end = 1'b1;
    @(negedge clk); #1 tick_1s = 1'b0; sr_rd_end = 1'b0;
    check("R4", flag1, 1, "match on end strobe wins");
    rd_pulse(1, 0); rd_pulse(0, 1);
    @(negedge clk);
    check("R4", flag1, 0, "cleared by second read");

    // R2: empty mask never matches
    cur_req = "R2";
    alm0_cfg = pack_t(8'h30, 8'h15, 8'h07, 8'h21, 8'h03, 8'h05);
    alm1_cfg = '0;
    sec_tick();
    @(negedge clk);
    check("R2", flag0, 0, "no enabled fields alm0");
    check("R2", flag1, 0, "no enabled fields alm1");

    // R3: matching time without tick sets nothing
    cur_req = "R3";
    alm0_cfg = pack_t(8'hB0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h85);
    idle(5);
    check("R3", flag0, 0, "no tick no flag");
    @(negedge clk); #1 tick_1s = 1'b1;
    @(negedge clk);
    check("R3", flag0, 1, "flag visible cycle after tick");
    #1 tick_1s = 1'b0;

    // R5: level interrupt
    cur_req = "R5";
    irq_en0 = 1'b1;
    idle(2);
    check("R5", pin_pull, 1, "level pin with flag set");
    rd_pulse(1, 0); rd_pulse(0, 1);
    idle(2);
    check("R5", pin_pull, 0, "level pin released after clear");

    // R6: pulse mode with retrigger
    cur_req = "R6";
    pulse_mode = 1'b1;
    t32_period = 2;
    sec_tick();
    idle(20);
    check("R6", pin_pull, 1, "pulse active");
    sec_tick();
    idle(2 * HALF + 10);
    check("R6", pin_pull, 0, "pulse ended");

    // R7: frequency codes, with an alarm flag set
    cur_req = "R7";
    pulse_mode = 1'b0;
    sec_tick();
    fsel = 2'b01; t32_period = 3; idle(40);
    fsel = 2'b10; t32_period = 1; idle(40);
    fsel = 2'b11; idle(3 * (1 << DIV_W));
    fsel = 2'b10; t32_period = 2; idle(60);

    // R8: enables off, interrupt code
    cur_req = "R8";
    fsel = 2'b00; irq_en0 = 1'b0; irq_en1 = 1'b0;
    sec_tick();
    idle(4);
    check("R8", pin_pull, 0, "no enables no pull");
    check("R8", flag0, 1, "flag still set");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule